// File: doc/BRIEF.md
# Operand Interlock and Bypass Timer

This block sits beside the issue stage of a four-stage in-order pipeline: fetch, issue/address-generation, execute, and a load-completion stage that follows execute. Each cycle it receives one micro-op in the issue stage. That micro-op can carry up to `NSRC` source operands. Each operand is tagged with the stage in which it is consumed: issue for address inputs, execute for data inputs. The micro-op also carries an optional destination register, tagged with the stage in which its result becomes available: execute for arithmetic results, or the load-completion stage for load data.

The block keeps a short age-ordered record of the destination registers of the micro-ops that have left issue. From each recorded producer's age and ready stage, and from the consumer's need stage, it works out whether the operand can be bypassed this cycle or whether the issue-stage micro-op must be held. While a micro-op is held, a bubble enters execute. For every operand the block also gives a forwarding select naming which in-flight age supplies the value. Comparison is done per micro-op, so multi-word loads and two-step multiply-accumulates are handled by presenting their micro-ops one after another.

Top module: `opnd_interlock`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the in-flight record is empty: no operand causes a stall and every forwarding select is 0 (register file).
- R2: A producer that is ready in execute and is one cycle ahead of a consumer needing the operand in execute causes no stall, and the forwarding select is 1 (producer currently in execute).
- R3: A producer that is ready in execute and is one cycle ahead of a consumer needing the operand in issue holds the consumer for exactly one cycle. The consumer then proceeds with a forwarding select of 2 (producer currently in load-completion).
- R4: A load producer (ready in load-completion) one cycle ahead of a consumer needing the operand in execute holds the consumer for one cycle. The consumer then proceeds with a forwarding select of 2.
- R5: A load producer one cycle ahead of a consumer needing the operand in issue holds the consumer for two cycles. The consumer then proceeds with a forwarding select of 0.
- R6: A load producer two cycles ahead of a consumer needing the operand in issue holds the consumer for one cycle.
- R7: A producer is recorded only in a cycle where `ii_valid` is 1 and `stall` is 0; any other cycle places a bubble in execute. `stall` is 0 whenever `ii_valid` is 0.
- R8: When the same register is recorded at both ages, the younger producer wins: the forwarding select is 1.
- R9: Each micro-op of a multi-word load is compared on its own. A consumer in issue reading the register of the last micro-op right after it is held two cycles. Reading the register of the micro-op before the last is held one cycle.
- R10: An operand whose use flag is 0 never stalls and has a forwarding select of 0.
- R11: The stall is the OR over all operands. Each operand's forwarding select is derived independently from the others.
- R12: A producer that is ready in execute and is two cycles ahead needs no stall for either consumer kind, with a forwarding select of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ii_valid | input | 1 | A micro-op occupies the issue stage |
| ii_src_reg | input | NSRC*REG_W | Source register numbers, operand k at bits [k*REG_W +: REG_W] |
| ii_src_use | input | NSRC | Operand k is read by the micro-op |
| ii_src_at_ii | input | NSRC | 1: operand k is needed in issue (address); 0: needed in execute (data) |
| ii_dst_valid | input | 1 | The micro-op writes a destination register |
| ii_dst_reg | input | REG_W | Destination register number |
| ii_dst_late | input | 1 | 1: result ready in load-completion; 0: ready in execute |
| stall | output | 1 | Hold the issue-stage micro-op and send a bubble to execute |
| fwd_sel | output | NSRC*FW_W | Per operand: 0 register file, a = producer of age a (1 execute, 2 load-completion) |

## Verification
A single cycle-by-cycle stream drives the block through every pairing of producer ready stage (execute or load-completion) with consumer need stage (issue or execute), at distances one and two. This separates the zero-, one- and two-cycle hold classes and the select value each class ends on. Further patterns cover the following: a register recorded at both ages, which exposes age priority; an unused operand and an invalid micro-op sitting over a live hazard; three operands with different outcomes in one micro-op; and two-word load sequences, which show that the last and the next-to-last micro-op are timed separately. A reset applied over a pending load shows that the record is cleared.

// File: rtl/opil_pkg.sv
package opil_pkg;

   // Minimum issue distance between producer and consumer, in cycles.
   // A result ready in execute reaches an execute consumer one cycle later;
   // each of "ready one stage late" and "needed one stage early" adds one.
   function automatic int req_gap(input logic late, input logic at_ii);
      int g;
      g = 1;
      if (late)  g = g + 1;
      if (at_ii) g = g + 1;
      return g;
   endfunction

endpackage

// File: rtl/opil_track.sv
module opil_track #(
   parameter int REG_W = 5,
   parameter int AGE   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue,
   input  logic                 dst_v,
   input  logic [REG_W-1:0]     dst_reg,
   input  logic                 dst_late,
   output logic [AGE-1:0]       age_v,
   output logic [AGE*REG_W-1:0] age_reg,
   output logic [AGE-1:0]       age_late
);

   logic [AGE-1:0]       nxt_v;
   logic [AGE*REG_W-1:0] nxt_reg;
   logic [AGE-1:0]       nxt_late;

   // Age 1 takes the issuing micro-op (or a bubble); older ages shift.
   always_comb begin
      nxt_v[0]           = issue & dst_v;
      nxt_reg[REG_W-1:0] = dst_reg;
      nxt_late[0]        = dst_late;
      for (int a = 1; a < AGE; a++) begin
         nxt_v[a]                  = age_v[a-1];
         nxt_reg[a*REG_W +: REG_W] = age_reg[(a-1)*REG_W +: REG_W];
         nxt_late[a]               = age_late[a-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_v    <= '0;
         age_reg  <= '0;
         age_late <= '0;
      end else begin
         age_v    <= nxt_v;
         age_reg  <= nxt_reg;
         age_late <= nxt_late;
      end
   end

   AST_BUBBLE_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> !age_v[0]); // R7

   for (genvar a = 1; a < AGE; a++) begin : g_adv
      AST_AGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
         age_v[a-1] |=> (age_v[a] && age_reg[a*REG_W +: REG_W] == $past(age_reg[(a-1)*REG_W +: REG_W]))); // R5
   end

endmodule

// File: rtl/opil_opnd.sv
module opil_opnd
   import opil_pkg::*;
#(
   parameter int REG_W = 5,
   parameter int AGE   = 2,
   parameter int FW_W  = 2
) (
   input  logic [REG_W-1:0]     src_reg,
   input  logic                 src_use,
   input  logic                 src_at_ii,
   input  logic [AGE-1:0]       age_v,
   input  logic [AGE*REG_W-1:0] age_reg,
   input  logic [AGE-1:0]       age_late,
   output logic                 hold,
   output logic [FW_W-1:0]      fwd
);

   logic [AGE-1:0] hit;
   logic [AGE-1:0] short_gap;

   for (genvar a = 0; a < AGE; a++) begin : g_cmp
      assign hit[a] = src_use && age_v[a] && (age_reg[a*REG_W +: REG_W] == src_reg);
      // Producer of age a+1 is a+1 cycles ahead; too close if below the gap.
      assign short_gap[a] = hit[a] && ((a + 1) < req_gap(age_late[a], src_at_ii));
   end

   assign hold = |short_gap;

   // Youngest matching age wins: scan oldest first, later writes override.
   always_comb begin
      fwd = '0;
      for (int a = AGE - 1; a >= 0; a--) begin
         if (hit[a]) fwd = FW_W'(a + 1);
      end
   end

endmodule

// File: rtl/opnd_interlock.sv
module opnd_interlock #(
   parameter int NSRC              = 3,
   parameter int REG_W             = 5,
   parameter int AGE               = 2,
   parameter bit FWD_ZERO_ON_STALL = 1'b0,
   localparam int FW_W             = $clog2(AGE + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ii_valid,
   input  logic [NSRC*REG_W-1:0] ii_src_reg,
   input  logic [NSRC-1:0]       ii_src_use,
   input  logic [NSRC-1:0]       ii_src_at_ii,
   input  logic                  ii_dst_valid,
   input  logic [REG_W-1:0]      ii_dst_reg,
   input  logic                  ii_dst_late,
   output logic                  stall,
   output logic [NSRC*FW_W-1:0]  fwd_sel
);

   if (NSRC < 1) begin : g_bad_nsrc
      $error("opnd_interlock: NSRC must be at least 1");
   end
   if (REG_W < 1) begin : g_bad_regw
      $error("opnd_interlock: REG_W must be at least 1");
   end
   // The widest gap (load result, address consumer) is three cycles, so
   // producers must be visible for at least two ages.
   if (AGE < 2) begin : g_bad_age
      $error("opnd_interlock: AGE must be at least 2");
   end

   logic [AGE-1:0]       age_v;
   logic [AGE*REG_W-1:0] age_reg;
   logic [AGE-1:0]       age_late;
   logic [NSRC-1:0]      op_hold;
   logic [NSRC*FW_W-1:0] raw_fwd;
   logic                 issue;

   assign stall = ii_valid & (|op_hold);
   assign issue = ii_valid & ~stall;

   opil_track #(
      .REG_W (REG_W),
      .AGE   (AGE)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .dst_v    (ii_dst_valid),
      .dst_reg  (ii_dst_reg),
      .dst_late (ii_dst_late),
      .age_v    (age_v),
      .age_reg  (age_reg),
      .age_late (age_late)
   );

   for (genvar k = 0; k < NSRC; k++) begin : g_op
      opil_opnd #(
         .REG_W (REG_W),
         .AGE   (AGE),
         .FW_W  (FW_W)
      ) u_opnd (
         .src_reg   (ii_src_reg[k*REG_W +: REG_W]),
         .src_use   (ii_src_use[k]),
         .src_at_ii (ii_src_at_ii[k]),
         .age_v     (age_v),
         .age_reg   (age_reg),
         .age_late  (age_late),
         .hold      (op_hold[k]),
         .fwd       (raw_fwd[k*FW_W +: FW_W])
      );

      AST_UNUSED_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
         !ii_src_use[k] |-> (fwd_sel[k*FW_W +: FW_W] == '0)); // R10

      AST_FWD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         int'(fwd_sel[k*FW_W +: FW_W]) <= AGE); // R2
   end

   if (FWD_ZERO_ON_STALL) begin : g_fwd_gated
      assign fwd_sel = stall ? '0 : raw_fwd;
   end else begin : g_fwd_raw
      assign fwd_sel = raw_fwd;
   end

   AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !ii_valid |-> !stall); // R7

   AST_STALL_HAS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (|age_v)); // R3

   AST_FIRST_AFTER_RESET: assert property (@(posedge clk)
      !rst_n |=> !stall); // R1

endmodule

// File: tb/opnd_interlock_tb.sv
module opnd_interlock_tb;

   localparam int NSRC  = 3;
   localparam int REG_W = 5;
   localparam int FW_W  = 2;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic                  ii_valid;
   logic [NSRC*REG_W-1:0] ii_src_reg;
   logic [NSRC-1:0]       ii_src_use;
   logic [NSRC-1:0]       ii_src_at_ii;
   logic                  ii_dst_valid;
   logic [REG_W-1:0]      ii_dst_reg;
   logic                  ii_dst_late;
   logic                  stall;
   logic [NSRC*FW_W-1:0]  fwd_sel;

   int n_vec  = 0;
   int n_miss = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   opnd_interlock u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ii_valid     (ii_valid),
      .ii_src_reg   (ii_src_reg),
      .ii_src_use   (ii_src_use),
      .ii_src_at_ii (ii_src_at_ii),
      .ii_dst_valid (ii_dst_valid),
      .ii_dst_reg   (ii_dst_reg),
      .ii_dst_late  (ii_dst_late),
      .stall        (stall),
      .fwd_sel      (fwd_sel)
   );

   // One row per clock cycle; held micro-ops are repeated in following rows.
   // uz/aii bit k belongs to operand k. Select codes: 0 RF, 1 age 1, 2 age 2.
   typedef struct packed {
      logic       v;
      logic [4:0] s0;
      logic [4:0] s1;
      logic [4:0] s2;
      logic [2:0] uz;
      logic [2:0] aii;
      logic       dv;
      logic [4:0] d;
      logic       late;
      logic       st;
      logic [1:0] f0;
      logic [1:0] f1;
      logic [1:0] f2;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 40;
   localparam vec_t VT [NV] = '{
      '{1'b1,5'd1, 5'd0, 5'd0, 3'b001,3'b001,1'b1,5'd1, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd1},  // R1 empty after reset
      '{1'b1,5'd1, 5'd0, 5'd0, 3'b001,3'b000,1'b1,5'd2, 1'b0,1'b0,2'd1,2'd0,2'd0,8'd2},  // R2
      '{1'b1,5'd1, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd2,2'd0,2'd0,8'd12}, // R12 address
      '{1'b1,5'd2, 5'd0, 5'd0, 3'b001,3'b001,1'b1,5'd3, 1'b0,1'b0,2'd2,2'd0,2'd0,8'd12}, // R12
      '{1'b1,5'd3, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b1,2'd1,2'd0,2'd0,8'd3},  // R3 held
      '{1'b1,5'd3, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd2,2'd0,2'd0,8'd3},  // R3 proceeds
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd4, 1'b1,1'b0,2'd0,2'd0,2'd0,8'd4},  // R4 load
      '{1'b1,5'd4, 5'd0, 5'd0, 3'b001,3'b000,1'b0,5'd0, 1'b0,1'b1,2'd1,2'd0,2'd0,8'd4},  // R4 held
      '{1'b1,5'd4, 5'd0, 5'd0, 3'b001,3'b000,1'b0,5'd0, 1'b0,1'b0,2'd2,2'd0,2'd0,8'd4},  // R4 proceeds
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd5, 1'b1,1'b0,2'd0,2'd0,2'd0,8'd5},  // R5 load
      '{1'b1,5'd5, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b1,2'd1,2'd0,2'd0,8'd5},  // R5 held 1
      '{1'b1,5'd5, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b1,2'd2,2'd0,2'd0,8'd5},  // R5 held 2
      '{1'b1,5'd5, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd5},  // R5 proceeds
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd6, 1'b1,1'b0,2'd0,2'd0,2'd0,8'd6},  // R6 load
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd6},  // R6 filler
      '{1'b1,5'd6, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b1,2'd2,2'd0,2'd0,8'd6},  // R6 held
      '{1'b1,5'd6, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd6},  // R6 proceeds
      '{1'b0,5'd7, 5'd0, 5'd0, 3'b001,3'b001,1'b1,5'd7, 1'b1,1'b0,2'd0,2'd0,2'd0,8'd7},  // R7 invalid, not recorded
      '{1'b1,5'd7, 5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd7},  // R7 no hazard seen
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd17,1'b1,1'b0,2'd0,2'd0,2'd0,8'd7},  // R7 load
      '{1'b0,5'd17,5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd1,2'd0,2'd0,8'd7},  // R7 invalid over hazard
      '{1'b1,5'd17,5'd0, 5'd0, 3'b001,3'b000,1'b0,5'd0, 1'b0,1'b0,2'd2,2'd0,2'd0,8'd7},  // R7
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd8, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd8},  // R8 producer A
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd8, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd8},  // R8 producer B
      '{1'b1,5'd8, 5'd0, 5'd0, 3'b001,3'b000,1'b0,5'd0, 1'b0,1'b0,2'd1,2'd0,2'd0,8'd8},  // R8 younger wins
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd9, 1'b1,1'b0,2'd0,2'd0,2'd0,8'd10}, // R10 load
      '{1'b1,5'd9, 5'd0, 5'd0, 3'b000,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd10}, // R10 unused
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd10,1'b0,1'b0,2'd0,2'd0,2'd0,8'd11}, // R11 early
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd11,1'b1,1'b0,2'd0,2'd0,2'd0,8'd11}, // R11 load
      '{1'b1,5'd10,5'd11,5'd12,3'b111,3'b000,1'b0,5'd0, 1'b0,1'b1,2'd2,2'd1,2'd0,8'd11}, // R11 held
      '{1'b1,5'd10,5'd11,5'd12,3'b111,3'b000,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd2,2'd0,8'd11}, // R11 proceeds
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd13,1'b1,1'b0,2'd0,2'd0,2'd0,8'd9},  // R9 word 1
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd14,1'b1,1'b0,2'd0,2'd0,2'd0,8'd9},  // R9 word 2 (last)
      '{1'b1,5'd13,5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b1,2'd2,2'd0,2'd0,8'd9},  // R9 next-to-last held
      '{1'b1,5'd13,5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd9},  // R9 proceeds
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd15,1'b1,1'b0,2'd0,2'd0,2'd0,8'd9},  // R9 word 1
      '{1'b1,5'd0, 5'd0, 5'd0, 3'b000,3'b000,1'b1,5'd16,1'b1,1'b0,2'd0,2'd0,2'd0,8'd9},  // R9 word 2 (last)
      '{1'b1,5'd16,5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b1,2'd1,2'd0,2'd0,8'd9},  // R9 last held 1
      '{1'b1,5'd16,5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b1,2'd2,2'd0,2'd0,8'd9},  // R9 last held 2
      '{1'b1,5'd16,5'd0, 5'd0, 3'b001,3'b001,1'b0,5'd0, 1'b0,1'b0,2'd0,2'd0,2'd0,8'd9}   // R9 proceeds
   };

   task automatic drive(input vec_t t);
      ii_valid     = t.v;
      ii_src_reg   = {t.s2, t.s1, t.s0};
      ii_src_use   = t.uz;
      ii_src_at_ii = t.aii;
      ii_dst_valid = t.dv;
      ii_dst_reg   = t.d;
      ii_dst_late  = t.late;
   endtask

   task automatic check(input int idx, input int req, input logic est, input logic [5:0] ef);
      n_vec++;
      if (stall !== est || fwd_sel !== ef) begin
         n_miss++;
         $display("FAIL vector %0d R%0d: stall=%0b fwd=%h, expected stall=%0b fwd=%h",
                  idx, req, stall, fwd_sel, est, ef);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   endtask

   localparam vec_t IDLE = '{1'b0,5'd0,5'd0,5'd0,3'b000,3'b000,1'b0,5'd0,1'b0,1'b0,2'd0,2'd0,2'd0,8'd0};

   initial begin
      rst_n = 1'b0;
      drive(IDLE);
      repeat (3) @(negedge clk);
      #1 check(-1, 1, 1'b0, 6'h00);          // R1 reset state
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VT[i]);
         #1 check(i, int'(VT[i].req), VT[i].st, {VT[i].f2, VT[i].f1, VT[i].f0});
      end

      // Directed: reset applied over a pending load clears the record (R1).
      @(negedge clk);
      drive('{1'b1,5'd0,5'd0,5'd0,3'b000,3'b000,1'b1,5'd20,1'b1,1'b0,2'd0,2'd0,2'd0,8'd1});
      @(negedge clk);
      rst_n = 1'b0;
      drive('{1'b1,5'd20,5'd0,5'd0,3'b001,3'b001,1'b0,5'd0,1'b0,1'b0,2'd0,2'd0,2'd0,8'd1});
      @(negedge clk);
      #1 check(100, 1, 1'b0, 6'h00);         // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      #1 check(101, 1, 1'b0, 6'h00);         // R1 first cycle after reset

      // Directed: same address consumer held two cycles, then free (R5 corner).
      drive('{1'b1,5'd0,5'd0,5'd0,3'b000,3'b000,1'b1,5'd21,1'b1,1'b0,2'd0,2'd0,2'd0,8'd5});
      @(negedge clk);
      drive('{1'b1,5'd21,5'd21,5'd0,3'b011,3'b001,1'b0,5'd0,1'b0,1'b0,2'd0,2'd0,2'd0,8'd5});
      #1 check(102, 5, 1'b1, {2'd0, 2'd1, 2'd1}); // R5 / R11 both operands see age 1
      @(negedge clk);
      #1 check(103, 5, 1'b1, {2'd0, 2'd2, 2'd2}); // R5
      @(negedge clk);
      #1 check(104, 5, 1'b0, 6'h00);         // R5
      @(negedge clk);
      drive(IDLE);
      @(negedge clk);
      finish_run();
   end

   initial begin
      #(4 * 200000);
      n_miss++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule